// File: doc/BRIEF.md
# Self-Clearing Soft Reset and FIFO Flush Sequencer

This block accepts software requests for five maintenance operations: a full core soft reset, a reset of the bus-side control logic only, a transmit FIFO flush, a receive FIFO flush and a restart of the frame counter. Software sets a request bit with a write. The bit stays at 1 while the operation is pending or running and returns to 0 when the operation has finished, so software polls the bit to learn when the operation is complete. Writing 0 to a bit never cancels an operation.

The four timed operations run one at a time. Each one starts with a single-cycle pulse on its own output. The FIFOs and state machines that the pulses act on are outside this block. Durations are counted in fast-clock cycles. The flush durations are scaled by a parameter that gives the ratio of the slower clock to this clock. The frame restart does not use the timed engine. It waits for the next start-of-frame event, and that event then carries frame number 0. Bit 31 of the status word reports that the bus master is idle. A ready flag holds off accesses to the PHY domain for a short settling time after a core reset.

Top module: `soft_reset_seq`

## Requirements
- R1: After reset, `status_o` reads 0 except bit 31, which equals the inverse of `mst_busy_i`. `frame_num_o` is 0, `phy_ready_o` is 1 and all pulse outputs are low.
- R2: A cycle with `req_wr_i` high sets each status bit whose `req_bits_i` bit is 1. A 0 in a request bit has no effect. The bit assignment is: bit 0 core reset, bit 1 control reset, bit 2 transmit flush, bit 3 receive flush, bit 4 frame restart. `status_o[4:0]` reads these bits back.
- R3: A transmit flush requested while nothing else is active keeps bit 2 at 1 for 8*CLK_RATIO+1 cycles, counted from the write edge. It produces exactly one single-cycle pulse on `txf_flush_pulse_o`.
- R4: A receive flush behaves in the same way on bit 3 and `rxf_flush_pulse_o`, with the same 8*CLK_RATIO duration.
- R5: A control reset keeps bit 1 at 1 for CTL_CYC+1 cycles and gives one pulse on `ctl_rst_pulse_o`. It produces no flush pulse, and flush requests that are pending while it runs stay pending.
- R6: A core reset keeps bit 0 at 1 for CORE_CYC+1 cycles and gives one pulse on `core_rst_pulse_o`. When it starts, it drops every other pending request and sets the frame number to 0. Writes to bits 1 to 4 are ignored while it runs.
- R7: Pending timed operations run one at a time in this fixed order: core reset, control reset, transmit flush, receive flush. Each operation starts one idle cycle after the previous one ends.
- R8: Bit 4 stays at 1 until the next start-of-frame (`sof_i` high). That event sets `frame_num_o` to 0 and clears bit 4.
- R9: Every other start-of-frame increments `frame_num_o`. The count wraps from 2^FN_W-1 to 0.
- R10: Bit 31 is 1 only when `mst_busy_i` is low and neither a core reset nor a control reset is running. Bits 30 to 5 read 0.
- R11: `phy_ready_o` is low from the start of a core reset until 3*CLK_RATIO cycles after bit 0 clears.
- R12: At most one pulse output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr_i | input | 1 | Request write strobe |
| req_bits_i | input | 5 | Request bits to set |
| mst_busy_i | input | 1 | Bus master has a transfer in progress |
| sof_i | input | 1 | Start-of-frame event |
| status_o | output | 32 | Request bits [4:0], idle flag [31] |
| frame_num_o | output | FN_W | Current frame number |
| phy_ready_o | output | 1 | PHY-domain access allowed |
| core_rst_pulse_o | output | 1 | Core reset start pulse |
| ctl_rst_pulse_o | output | 1 | Control reset start pulse |
| txf_flush_pulse_o | output | 1 | Transmit flush start pulse |
| rxf_flush_pulse_o | output | 1 | Receive flush start pulse |

## Verification
The assertions check on every cycle that:
- at most one pulse is high, and it belongs to the operation that is running;
- the running operation does not change while its countdown is nonzero;
- a request bit falls only on completion or on a core reset start;
- the frame number steps correctly on each start-of-frame;
- the ready flag drops after a core reset.

Only the bench scenarios can show the full request-bit durations, the order and spacing of operations that were queued together, the dropping of pending work by a core reset, the counter wrap and the length of the PHY settling window.

// File: rtl/srs_pkg.sv
// Shared constants and types for the soft reset sequencer.
// Assumes a 32-bit status word with the idle flag in its top bit.
package srs_pkg;
    localparam int NREQ     = 5;
    localparam int NOPS     = 4;
    localparam int REG_W    = 32;
    localparam int IDLE_BIT = REG_W - 1;
    localparam int B_CORE   = 0;
    localparam int B_CTL    = 1;
    localparam int B_TXF    = 2;
    localparam int B_RXF    = 3;
    localparam int B_FRM    = 4;

    // Slot order is also service priority: lower value wins.
    typedef enum logic [1:0] {
        SL_CORE = 2'd0,
        SL_CTL  = 2'd1,
        SL_TXF  = 2'd2,
        SL_RXF  = 2'd3
    } slot_e;
endpackage

// File: rtl/srs_req_reg.sv
// Request bit bank: one sticky bit per operation.
// A write sets bits, and completion clears them. A core reset start
// drops all non-core bits and blocks writes to them while it runs.
// Assumes clr_i is a single-cycle completion indication per bit.
module srs_req_reg
    import srs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NREQ-1:0] wdata_i,
    input  logic [NREQ-1:0] clr_i,
    input  logic            core_start_i,
    input  logic            core_run_i,
    output logic [NREQ-1:0] req_o
);
    logic [NREQ-1:0] req_q;

    for (genvar gi = 0; gi < NREQ; gi++) begin : g_bit
        if (gi == B_CORE) begin : g_core
            logic set_w;
            assign set_w = wr_i & wdata_i[gi];
            // Core bit: set by write, cleared by its own completion.
            always_ff @(posedge clk) begin
                if (!rst_n)          req_q[gi] <= 1'b0;
                else if (clr_i[gi])  req_q[gi] <= 1'b0;
                else if (set_w)      req_q[gi] <= 1'b1;
            end
        end else begin : g_other
            logic set_w;
            assign set_w = wr_i & wdata_i[gi] & ~core_run_i & ~core_start_i;
            // Other bits: dropped by core reset start, else set/clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                          req_q[gi] <= 1'b0;
                else if (core_start_i || clr_i[gi])  req_q[gi] <= 1'b0;
                else if (set_w)                      req_q[gi] <= 1'b1;
            end
            // R2/R6: a bit only falls on its completion or a core reset start
            a_r2_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(req_q[gi]) |-> $past(clr_i[gi] || core_start_i));
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/srs_op_engine.sv
// Timed operation engine. It picks the highest-priority pending
// operation while idle, issues its start pulse and counts down its
// duration. At the end it signals completion for that request bit.
// Assumes every duration parameter is at least 1.
module srs_op_engine
    import srs_pkg::*;
#(
    parameter int CLK_RATIO = 2,
    parameter int CORE_CYC  = 16,
    parameter int CTL_CYC   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NOPS-1:0] req_i,
    output logic            busy_o,
    output slot_e           slot_o,
    output logic [NOPS-1:0] done_o,
    output logic [NOPS-1:0] pulse_o,
    output logic            core_start_o,
    output logic            core_done_o
);
    localparam int FLUSH_CYC = 8 * CLK_RATIO;
    localparam int CC_MAX    = (CORE_CYC > CTL_CYC) ? CORE_CYC : CTL_CYC;
    localparam int MAX_CYC   = (CC_MAX > FLUSH_CYC) ? CC_MAX : FLUSH_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             busy_q;
    slot_e            slot_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NOPS-1:0]  pulse_q;
    slot_e            pick;
    logic             start_w;
    logic             last_w;

    function automatic logic [NOPS-1:0] slot_oh(slot_e s);
        return {{(NOPS-1){1'b0}}, 1'b1} << s;
    endfunction

    function automatic logic [CNT_W-1:0] load_of(slot_e s);
        case (s)
            SL_CORE: return CNT_W'(CORE_CYC - 1);
            SL_CTL:  return CNT_W'(CTL_CYC - 1);
            default: return CNT_W'(FLUSH_CYC - 1);
        endcase
    endfunction

    // Fixed-priority pick: the lowest-numbered pending slot wins.
    always_comb begin
        pick = SL_RXF;
        for (int i = NOPS - 1; i >= 0; i--) begin
            if (req_i[i]) pick = slot_e'(2'(i));
        end
    end

    assign start_w = !busy_q && (|req_i);
    assign last_w  = busy_q && (cnt_q == '0);

    // Operation state: idle, or running one slot with a countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= SL_CORE;
            cnt_q  <= '0;
        end else if (start_w) begin
            busy_q <= 1'b1;
            slot_q <= pick;
            cnt_q  <= load_of(pick);
        end else if (last_w) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Start pulse: one cycle, for the slot that just began.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= start_w ? slot_oh(pick) : '0;
    end

    assign busy_o       = busy_q;
    assign slot_o       = slot_q;
    assign pulse_o      = pulse_q;
    assign done_o       = last_w ? slot_oh(slot_q) : '0;
    assign core_start_o = start_w && (pick == SL_CORE);
    assign core_done_o  = last_w && (slot_q == SL_CORE);

    // R12: never more than one start pulse at a time
    a_r12_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_q));
    // R7: a pulse belongs to the operation now running
    a_r7_pulse_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q != '0) |-> (busy_q && pulse_q == slot_oh(slot_q)));
    // R7: no preemption while the countdown runs
    a_r7_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && $stable(slot_q)));
    // R3: completion returns to idle for one cycle
    a_r3_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        last_w |=> !busy_q);
endmodule

// File: rtl/srs_frame_ctr.sv
// Frame number counter. It steps on each start-of-frame and wraps at
// its width. A pending restart makes the next start-of-frame load 0.
// It is held at 0 while a core reset starts or runs.
module srs_frame_ctr #(
    parameter int FN_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_i,
    input  logic            restart_i,
    input  logic            hold_i,
    output logic            restart_done_o,
    output logic [FN_W-1:0] fn_o
);
    localparam logic [FN_W-1:0] FN_MAX = {FN_W{1'b1}};

    logic [FN_W-1:0] fn_q;

    assign restart_done_o = sof_i && restart_i && !hold_i;

    // Frame number update on start-of-frame, restart or core reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              fn_q <= '0;
        else if (hold_i)         fn_q <= '0;
        else if (sof_i) begin
            if (restart_i)       fn_q <= '0;
            else if (fn_q == FN_MAX) fn_q <= '0;
            else                 fn_q <= fn_q + 1'b1;
        end
    end

    assign fn_o = fn_q;

    // R8: a start-of-frame with a pending restart carries number 0
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && restart_i && !hold_i) |=> (fn_q == '0));
    // R9: a plain start-of-frame below the top value adds one
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && !restart_i && !hold_i && fn_q != FN_MAX) |=> (fn_q == $past(fn_q) + 1'b1));
endmodule

// File: rtl/srs_phy_guard.sv
// PHY access guard. It clears ready while a core reset runs and keeps
// it low for a settling window after the reset ends.
module srs_phy_guard #(
    parameter int CLK_RATIO = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_run_i,
    input  logic core_done_i,
    output logic ready_o
);
    localparam int PHY_DLY = 3 * CLK_RATIO;
    localparam int PW      = $clog2(PHY_DLY + 1);

    logic [PW-1:0] wait_q;

    // Settling countdown, loaded when a core reset finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)             wait_q <= '0;
        else if (core_done_i)   wait_q <= PW'(PHY_DLY);
        else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
    end

    assign ready_o = !core_run_i && (wait_q == '0);

    // R11: no PHY access right after a core reset ends
    a_r11_settle_after_core: assert property (@(posedge clk) disable iff (!rst_n)
        core_done_i |=> !ready_o);
endmodule

// File: rtl/soft_reset_seq.sv
// Top level of the soft reset and FIFO flush sequencer. It joins the
// request bank, the timed engine, the frame counter and the PHY guard,
// and it assembles the 32-bit status word.
// Assumes the write strobe and start-of-frame events are synchronous to clk.
module soft_reset_seq
    import srs_pkg::*;
#(
    parameter int CLK_RATIO = 2,
    parameter int CORE_CYC  = 16,
    parameter int CTL_CYC   = 6,
    parameter int FN_W      = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr_i,
    input  logic [4:0]       req_bits_i,
    input  logic             mst_busy_i,
    input  logic             sof_i,
    output logic [31:0]      status_o,
    output logic [FN_W-1:0]  frame_num_o,
    output logic             phy_ready_o,
    output logic             core_rst_pulse_o,
    output logic             ctl_rst_pulse_o,
    output logic             txf_flush_pulse_o,
    output logic             rxf_flush_pulse_o
);
    logic [NREQ-1:0] req_q;
    logic [NREQ-1:0] clr_w;
    logic [NOPS-1:0] done_w;
    logic [NOPS-1:0] pulse_w;
    logic            busy_w;
    slot_e           slot_w;
    logic            core_start_w;
    logic            core_done_w;
    logic            core_run_w;
    logic            ctl_run_w;
    logic            frm_done_w;
    logic            idle_w;

    assign core_run_w = busy_w && (slot_w == SL_CORE);
    assign ctl_run_w  = busy_w && (slot_w == SL_CTL);
    assign clr_w      = {frm_done_w, done_w};

    srs_req_reg u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (req_wr_i),
        .wdata_i      (req_bits_i),
        .clr_i        (clr_w),
        .core_start_i (core_start_w),
        .core_run_i   (core_run_w),
        .req_o        (req_q)
    );

    srs_op_engine #(
        .CLK_RATIO (CLK_RATIO),
        .CORE_CYC  (CORE_CYC),
        .CTL_CYC   (CTL_CYC)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_q[NOPS-1:0]),
        .busy_o       (busy_w),
        .slot_o       (slot_w),
        .done_o       (done_w),
        .pulse_o      (pulse_w),
        .core_start_o (core_start_w),
        .core_done_o  (core_done_w)
    );

    srs_frame_ctr #(
        .FN_W (FN_W)
    ) u_frm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sof_i          (sof_i),
        .restart_i      (req_q[B_FRM]),
        .hold_i         (core_start_w || core_run_w),
        .restart_done_o (frm_done_w),
        .fn_o           (frame_num_o)
    );

    srs_phy_guard #(
        .CLK_RATIO (CLK_RATIO)
    ) u_phy (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_run_i  (core_run_w),
        .core_done_i (core_done_w),
        .ready_o     (phy_ready_o)
    );

    assign idle_w   = !mst_busy_i && !core_run_w && !ctl_run_w;
    assign status_o = {idle_w, {(REG_W - 1 - NREQ){1'b0}}, req_q};

    assign core_rst_pulse_o  = pulse_w[B_CORE];
    assign ctl_rst_pulse_o   = pulse_w[B_CTL];
    assign txf_flush_pulse_o = pulse_w[B_TXF];
    assign rxf_flush_pulse_o = pulse_w[B_RXF];

    // R10: the idle flag is low in the cycle a core reset starts
    a_r10_not_idle_on_core: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_pulse_o |-> !status_o[IDLE_BIT]);
    // R10: the idle flag is low in the cycle a control reset starts
    a_r10_not_idle_on_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_pulse_o |-> !status_o[IDLE_BIT]);
endmodule

// File: tb/soft_reset_seq_tb.sv
module soft_reset_seq_tb;
    localparam int RATIO = 2;
    localparam int CORE  = 16;
    localparam int CTL   = 6;
    localparam int FNW   = 14;
    localparam int FLUSH = 8 * RATIO;
    localparam int PHYW  = 3 * RATIO;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_wr = 1'b0;
    logic [4:0]      req_bits = '0;
    logic            mst_busy = 1'b0;
    logic            sof = 1'b0;
    logic [31:0]     status;
    logic [FNW-1:0]  fnum;
    logic            phy_rdy;
    logic            p_core, p_ctl, p_txf, p_rxf;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int cyc = 0;
    int pcnt [4];
    int last_t [4];

    always #10 clk = ~clk;

    soft_reset_seq #(.CLK_RATIO(RATIO), .CORE_CYC(CORE), .CTL_CYC(CTL), .FN_W(FNW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_wr_i(req_wr), .req_bits_i(req_bits),
        .mst_busy_i(mst_busy), .sof_i(sof), .status_o(status), .frame_num_o(fnum),
        .phy_ready_o(phy_rdy), .core_rst_pulse_o(p_core), .ctl_rst_pulse_o(p_ctl),
        .txf_flush_pulse_o(p_txf), .rxf_flush_pulse_o(p_rxf)
    );

    // Pulse monitor: samples the settled pre-edge values at each rising edge.
    initial for (int k = 0; k < 4; k++) begin pcnt[k] = 0; last_t[k] = 0; end
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (p_core) begin pcnt[0] <= pcnt[0] + 1; last_t[0] <= cyc; end
        if (p_ctl)  begin pcnt[1] <= pcnt[1] + 1; last_t[1] <= cyc; end
        if (p_txf)  begin pcnt[2] <= pcnt[2] + 1; last_t[2] <= cyc; end
        if (p_rxf)  begin pcnt[3] <= pcnt[3] + 1; last_t[3] <= cyc; end
    end

    function automatic int exp_len(input int b);
        if (b == 0) return CORE + 1;
        if (b == 1) return CTL + 1;
        return FLUSH + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic write_req(input logic [4:0] v);
        @(negedge clk);
        req_wr = 1'b1; req_bits = v;
        @(negedge clk);
        req_wr = 1'b0; req_bits = '0;
    endtask

    task automatic sof_burst(input int n);
        @(negedge clk);
        sof = 1'b1;
        repeat (n) @(negedge clk);
        sof = 1'b0;
    endtask

    // Runs one timed operation from idle and checks length, pulses, idle flag.
    task automatic run_op(input int b, input bit mst);
        int n;
        int p0 [4];
        for (int k = 0; k < 4; k++) p0[k] = pcnt[k];
        mst_busy = mst;
        write_req(5'(1 << b));
        n = 0;
        while (status[b] && n < 400) begin
            if (n == 1) chk(status[31] == ((b == 1) ? 1'b0 : !mst), "R10 idle flag during op",
                            int'(status[31]), (b == 1) ? 0 : int'(!mst));
            n++;
            @(negedge clk);
        end
        if (b == 2)      chk(n == exp_len(b), "R3 tx flush bit length", n, exp_len(b));
        else if (b == 3) chk(n == exp_len(b), "R4 rx flush bit length", n, exp_len(b));
        else             chk(n == exp_len(b), "R5 ctl reset bit length", n, exp_len(b));
        for (int k = 0; k < 4; k++)
            chk(pcnt[k] - p0[k] == ((k == b) ? 1 : 0), "R12 R5 pulse count per op",
                pcnt[k] - p0[k], (k == b) ? 1 : 0);
        mst_busy = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

    initial begin
        int r;
        int p0 [4];
        int n;
        r = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 32'h8000_0000, "R1 status after reset", int'(status), 32'h8000_0000);
        chk(fnum == '0, "R1 frame number after reset", int'(fnum), 0);
        chk(phy_rdy == 1'b1, "R1 phy ready after reset", int'(phy_rdy), 1);
        chk({p_core, p_ctl, p_txf, p_rxf} == 4'b0, "R1 pulses after reset",
            int'({p_core, p_ctl, p_txf, p_rxf}), 0);

        // R10 busy master clears the idle flag
        mst_busy = 1'b1;
        @(negedge clk);
        chk(status[31] == 1'b0, "R10 idle flag with busy master", int'(status[31]), 0);
        mst_busy = 1'b0;

        // R2 writing zeros sets nothing
        write_req(5'b0);
        chk(status[4:0] == 5'b0, "R2 zero write no effect", int'(status[4:0]), 0);

        // Directed single operations
        run_op(2, 1'b0);
        run_op(3, 1'b0);
        run_op(1, 1'b0);

        // R7 priority and spacing with three requests written together
        for (int k = 0; k < 4; k++) p0[k] = pcnt[k];
        write_req(5'b01110);
        chk(status[3:1] == 3'b111, "R2 three bits set", int'(status[3:1]), 7);
        @(negedge clk);
        chk(status[3:2] == 2'b11, "R5 flushes stay pending during ctl reset", int'(status[3:2]), 3);
        chk(status[31] == 1'b0, "R10 idle flag low in ctl reset", int'(status[31]), 0);
        n = 0;
        while (status[3:1] != 3'b0 && n < 400) begin n++; @(negedge clk); end
        for (int k = 1; k < 4; k++)
            chk(pcnt[k] - p0[k] == 1, "R7 each queued op pulses once", pcnt[k] - p0[k], 1);
        chk(last_t[2] - last_t[1] == CTL + 1, "R7 ctl before tx spacing", last_t[2] - last_t[1], CTL + 1);
        chk(last_t[3] - last_t[2] == FLUSH + 1, "R7 tx before rx spacing", last_t[3] - last_t[2], FLUSH + 1);

        // R8 frame restart waits for start-of-frame
        sof_burst(3);
        chk(fnum == 3, "R9 frame count steps", int'(fnum), 3);
        write_req(5'b10000);
        repeat (4) @(negedge clk);
        chk(status[4] == 1'b1, "R8 restart bit held until sof", int'(status[4]), 1);
        chk(fnum == 3, "R8 number unchanged before sof", int'(fnum), 3);
        sof_burst(1);
        chk(fnum == 0, "R8 sof carries frame zero", int'(fnum), 0);
        chk(status[4] == 1'b0, "R8 restart bit cleared", int'(status[4]), 0);
        sof_burst(1);
        chk(fnum == 1, "R9 count resumes after restart", int'(fnum), 1);

        // R6 core reset drops pending work, blocks writes, clears frame number
        sof_burst(2);
        for (int k = 0; k < 4; k++) p0[k] = pcnt[k];
        write_req(5'b11111);
        @(negedge clk);
        chk(phy_rdy == 1'b0, "R11 ready low in core reset", int'(phy_rdy), 0);
        chk(status[4:0] == 5'b00001, "R6 other requests dropped", int'(status[4:0]), 1);
        write_req(5'b00100);
        chk(status[4:0] == 5'b00001, "R6 write ignored during core reset", int'(status[4:0]), 1);
        n = 3;
        while (status[0] && n < 400) begin n++; @(negedge clk); end
        chk(n == exp_len(0), "R6 core reset bit length", n, exp_len(0));
        n = 0;
        while (!phy_rdy && n < 400) begin n++; @(negedge clk); end
        chk(n == PHYW, "R11 phy settle window", n, PHYW);
        repeat (5) @(negedge clk);
        chk(status[4:0] == 5'b0, "R6 nothing pending after core reset", int'(status[4:0]), 0);
        chk(fnum == 0, "R6 frame number cleared", int'(fnum), 0);
        for (int k = 0; k < 4; k++)
            chk(pcnt[k] - p0[k] == ((k == 0) ? 1 : 0), "R6 only core pulse",
                pcnt[k] - p0[k], (k == 0) ? 1 : 0);

        // Constrained random single operations with random master activity
        for (int it = 0; it < 24; it++) begin
            int b;
            int gap;
            b = int'($urandom_range(3, 1));
            gap = int'($urandom_range(5, 0));
            repeat (gap) @(negedge clk);
            run_op(b, 1'($urandom_range(1, 0)));
        end

        // R9 wrap at the counter width
        sof_burst((1 << FNW) - 1);
        chk(fnum == {FNW{1'b1}}, "R9 top frame number", int'(fnum), (1 << FNW) - 1);
        sof_burst(1);
        chk(fnum == '0, "R9 wrap to zero", int'(fnum), 0);

        summary();
    end
endmodule